// File: doc/BRIEF.md
# Timestamped Setpoint Scheduler

This block paces the setpoints of one motor axis. A show-ahead FIFO outside the block holds the setpoints. Each setpoint is three 32-bit words: a configuration word, a low timestamp word and a step word. The scheduler pulls one setpoint at a time and hands its step data and configuration bits to an external pulse generator. It then waits until a free-running relative time base equals the setpoint's 39-bit timestamp, and only then raises the generator's start strobe.

The first setpoint of a motion is held in an armed state until an external trigger shows a rising edge. That edge zeroes the relative time base. Later setpoints of the same motion go straight to the timestamp compare, so a whole profile runs against the single time origin set by the trigger.

A repeat mode runs one setpoint N times and re-arms the trigger between runs. Pause freezes the sequencer and the time base. Stop acts like pause and also blocks the trigger. An abort from any of three sources is widened into a fixed-length flush pulse for the FIFO, and it forces the sequencer back to idle ahead of every other input.

Top module: `setpoint_sched`

## Requirements
- R1: After reset, and in the idle state, `fifo_rd`, `gen_load`, `gen_start`, `armed` and `exec_pulse` are low and `gen_step`/`gen_cfg` are zero. The block leaves idle on the first clock edge that sees `fifo_empty` low.
- R2: One cycle after leaving idle, `fifo_rd` is high for exactly one cycle. In the next cycle `gen_load` is high for one cycle, with `gen_step` equal to the step word and `gen_cfg` equal to bits [31:7] of the configuration word.
- R3: The timestamp is {configuration word bits [6:0], timestamp word bits [31:0]}, 39 bits wide. For the first setpoint of a motion, `armed` rises only once `gen_ready` is high after the load. It stays high until a clock edge samples `trigger` high after sampling it low, and that edge clears the relative time base to zero.
- R4: While a motion is running, each further setpoint is read and compared without passing through the armed state. It is compared against the same time base, so a setpoint with timestamp T starts T+2 cycles after the clock edge that accepted the trigger.
- R5: In the waiting state, when the relative time equals the setpoint timestamp, `gen_start` rises on the next edge and `exec_pulse` is high for that first cycle only. With timestamp T, `gen_start` is first high T+2 edges after the accepting edge.
- R6: `gen_start` stays high until `gen_done` is sampled. The block then goes idle if the FIFO is empty, or reads the next setpoint if it is not.
- R7: With `rep_mode` high and `rep_n` = N (N ≥ 1), one setpoint is executed N times. The block returns to the armed state after each of the first N−1 completions. Each re-arm edge clears the time base again, and after the Nth completion the block follows R6.
- R8: Any of `host_abort`, `int_reset` or `pos_err` makes `fifo_flush` high for exactly 5 cycles, starting on the next edge. The same edge forces the idle state, even while pause is high.
- R9: While `pause` is high the state and the relative time base do not change, so every cycle of pause delays a pending start by one cycle.
- R10: While `stop` is high the state is frozen and trigger edges are discarded. A trigger that rose during stop and is still high when stop falls does not arm the motion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_empty | input | 1 | FIFO has no setpoint at its output register |
| fifo_word1 | input | 32 | Configuration word; [6:0] high timestamp bits |
| fifo_word2 | input | 32 | Low 32 timestamp bits |
| fifo_step | input | 32 | Step word for the generator |
| fifo_rd | output | 1 | FIFO read enable |
| fifo_flush | output | 1 | FIFO flush, 5-cycle abort pulse |
| gen_load | output | 1 | Generator load strobe |
| gen_step | output | 32 | Step word presented to the generator |
| gen_cfg | output | 25 | Configuration bits presented to the generator |
| gen_ready | input | 1 | Generator has accepted the setpoint |
| gen_done | input | 1 | Generator finished the current setpoint |
| gen_start | output | 1 | Generator start, high during execution |
| trigger | input | 1 | Motion trigger, rising edge arms the time base |
| pause | input | 1 | Freeze request |
| stop | input | 1 | Freeze request that also blocks the trigger |
| rep_mode | input | 1 | Repeat mode enable |
| rep_n | input | 8 | Number of runs in repeat mode |
| host_abort | input | 1 | Abort from the host |
| int_reset | input | 1 | Internal reset abort source |
| pos_err | input | 1 | Position-not-reached abort source |
| armed | output | 1 | Waiting for the trigger edge |
| exec_pulse | output | 1 | One-cycle execute indication to the host |

## Verification
A wrong time origin, or a timestamp assembled from the wrong bits, shows up as `gen_start` rising on a cycle other than T+2 after the accepted trigger. A bad field position pushes the start far enough out that the move never starts within the test window. A stale "motion running" flag shows either as an extra `armed` phase inside a profile or as a missing one on the next motion, visible within three cycles of the read. Abort, pause and stop faults appear at once as a wrong `fifo_flush` length, as a start that comes early or late by exactly the paused cycles, or as `armed` dropping while the trigger is blocked.

// File: rtl/setpoint_sched.sv
module setpoint_sched #(
  parameter int WORD_W    = 32,
  parameter int TS_HI_W   = 7,
  parameter int STEP_W    = 32,
  parameter int REP_W     = 8,
  parameter int ABORT_LEN = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      fifo_empty,
  input  logic [WORD_W-1:0]         fifo_word1,
  input  logic [WORD_W-1:0]         fifo_word2,
  input  logic [STEP_W-1:0]         fifo_step,
  output logic                      fifo_rd,
  output logic                      fifo_flush,
  output logic                      gen_load,
  output logic [STEP_W-1:0]         gen_step,
  output logic [WORD_W-TS_HI_W-1:0] gen_cfg,
  input  logic                      gen_ready,
  input  logic                      gen_done,
  output logic                      gen_start,
  input  logic                      trigger,
  input  logic                      pause,
  input  logic                      stop,
  input  logic                      rep_mode,
  input  logic [REP_W-1:0]          rep_n,
  input  logic                      host_abort,
  input  logic                      int_reset,
  input  logic                      pos_err,
  output logic                      armed,
  output logic                      exec_pulse
);
  localparam int TS_W  = TS_HI_W + WORD_W;
  localparam int CFG_W = WORD_W - TS_HI_W;
  localparam int ABT_W = $clog2(ABORT_LEN + 1);

  typedef enum logic [2:0] {S_IDLE, S_READ, S_ARMED, S_WAIT, S_EXEC} st_t;

  st_t              st, st_nx;
  logic             got, running, trig_q;
  logic [TS_W-1:0]  sp_ts, rel;
  logic [REP_W-1:0] rep_cnt;
  logic [REP_W:0]   rep_next;
  logic [ABT_W-1:0] abt_cnt;

  wire abt_src   = host_abort | int_reset | pos_err;
  wire abt_any   = abt_src | (abt_cnt != '0);
  wire hold      = pause | stop;
  wire trig_rise = trigger & ~trig_q & ~stop;
  wire go        = ~hold & ~abt_any;
  wire rd_fire   = go && st == S_READ && !got && !fifo_empty;
  wire arm_fire  = go && st == S_ARMED && trig_rise;
  wire ts_hit    = st == S_WAIT && rel == sp_ts;
  wire finish    = go && st == S_EXEC && gen_done;

  assign rep_next   = {1'b0, rep_cnt} + {{REP_W{1'b0}}, 1'b1};
  wire rep_more     = rep_mode && (rep_next < {1'b0, rep_n});

  assign fifo_rd    = rd_fire;
  assign fifo_flush = abt_cnt != '0;
  assign gen_start  = st == S_EXEC;
  assign armed      = st == S_ARMED;

  always_comb begin
    st_nx = st;
    if (abt_any) st_nx = S_IDLE;
    else if (!hold) begin
      case (st)
        S_IDLE:  if (!fifo_empty) st_nx = S_READ;
        S_READ:  if (got && gen_ready) st_nx = running ? S_WAIT : S_ARMED;
        S_ARMED: if (trig_rise) st_nx = S_WAIT;
        S_WAIT:  if (ts_hit) st_nx = S_EXEC;
        S_EXEC:  if (gen_done) st_nx = rep_more ? S_ARMED : (fifo_empty ? S_IDLE : S_READ);
        default: st_nx = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      got        <= 1'b0;
      running    <= 1'b0;
      trig_q     <= 1'b0;
      sp_ts      <= '0;
      rel        <= '0;
      rep_cnt    <= '0;
      abt_cnt    <= '0;
      gen_load   <= 1'b0;
      gen_step   <= '0;
      gen_cfg    <= '0;
      exec_pulse <= 1'b0;
    end else begin
      st         <= st_nx;
      trig_q     <= trigger;
      gen_load   <= rd_fire;
      exec_pulse <= go && ts_hit;

      if (abt_src)              abt_cnt <= ABT_W'(ABORT_LEN);
      else if (abt_cnt != '0)   abt_cnt <= abt_cnt - 1'b1;

      if (arm_fire)             rel <= '0;
      else if (!hold)           rel <= rel + 1'b1;

      if (rd_fire)              got <= 1'b1;
      else if (st_nx != S_READ) got <= 1'b0;

      if (rd_fire) begin
        sp_ts    <= {fifo_word1[TS_HI_W-1:0], fifo_word2};
        gen_step <= fifo_step;
        gen_cfg  <= fifo_word1[WORD_W-1:TS_HI_W];
      end else if (st_nx == S_IDLE) begin
        gen_step <= '0;
        gen_cfg  <= '0;
      end

      if (st_nx == S_IDLE)      running <= 1'b0;
      else if (arm_fire)        running <= 1'b1;

      if (abt_any)              rep_cnt <= '0;
      else if (finish)          rep_cnt <= rep_more ? rep_next[REP_W-1:0] : '0;
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> (!exec_pulse && gen_step == '0 && gen_cfg == '0))
    else $error("idle state with live outputs");

  assert_load_after_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |=> gen_load)
    else $error("read not followed by load");

  assert_arm_waits_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !trigger) |=> (armed || fifo_flush))
    else $error("armed state left without trigger");

  assert_exec_marks_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    exec_pulse |-> gen_start)
    else $error("execute indication without start");

  assert_start_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_start && !gen_done && !abt_src) |=> gen_start)
    else $error("start dropped before done");

  assert_abort_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    abt_src |=> (fifo_flush && !gen_start && !armed))
    else $error("abort did not flush and idle");

  always_ff @(posedge clk)
    if (rst_n) assert_abort_len_R8: assert (abt_cnt <= ABT_W'(ABORT_LEN))
      else $error("abort stretcher out of range");

  assert_pause_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pause && !abt_any) |=> $stable(st))
    else $error("state moved during pause");

  assert_stop_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && stop && !abt_src) |=> armed)
    else $error("trigger accepted during stop");
endmodule

// File: tb/test_setpoint_sched.sv
module test_setpoint_sched;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fifo_empty;
  logic [31:0] fifo_word1, fifo_word2, fifo_step;
  logic        fifo_rd, fifo_flush, gen_load, gen_start, armed, exec_pulse;
  logic [31:0] gen_step;
  logic [24:0] gen_cfg;
  logic        gen_ready = 1'b1, gen_done = 1'b0, trigger = 1'b0;
  logic        pause = 1'b0, stop = 1'b0, rep_mode = 1'b0;
  logic [7:0]  rep_n = 8'd1;
  logic        host_abort = 1'b0, int_reset = 1'b0, pos_err = 1'b0;

  int nchk = 0, nfail = 0;
  logic [31:0] m1 [16];
  logic [31:0] m2 [16];
  logic [31:0] m3 [16];
  int wp = 0;
  int rp = 0;

  always #4 clk = ~clk;

  assign fifo_empty = (rp == wp);
  assign fifo_word1 = m1[rp % 16];
  assign fifo_word2 = m2[rp % 16];
  assign fifo_step  = m3[rp % 16];

  always @(posedge clk)
    if (fifo_flush) rp <= wp;
    else if (fifo_rd) rp <= rp + 1;

  setpoint_sched i_setpoint_sched (
    .clk(clk), .rst_n(rst_n), .fifo_empty(fifo_empty), .fifo_word1(fifo_word1),
    .fifo_word2(fifo_word2), .fifo_step(fifo_step), .fifo_rd(fifo_rd),
    .fifo_flush(fifo_flush), .gen_load(gen_load), .gen_step(gen_step),
    .gen_cfg(gen_cfg), .gen_ready(gen_ready), .gen_done(gen_done),
    .gen_start(gen_start), .trigger(trigger), .pause(pause), .stop(stop),
    .rep_mode(rep_mode), .rep_n(rep_n), .host_abort(host_abort),
    .int_reset(int_reset), .pos_err(pos_err), .armed(armed), .exec_pulse(exec_pulse)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] w1, input logic [31:0] w2, input logic [31:0] w3);
    m1[wp % 16] = w1; m2[wp % 16] = w2; m3[wp % 16] = w3;
    wp = wp + 1;
  endtask

  task automatic wait_armed(input string req);
    int n = 0;
    while (!armed && n < 50) begin tick(); n++; end
    chk(req, armed, 1);
  endtask

  task automatic wait_start(output int n);
    n = 1;
    while (!gen_start && n < 80) begin tick(); n++; end
  endtask

  task automatic t_reset();
    chk("R1 reset rd",    fifo_rd, 0);
    chk("R1 reset flush", fifo_flush, 0);
    chk("R1 reset load",  gen_load, 0);
    chk("R1 reset step",  gen_step, 0);
    chk("R1 reset start", gen_start, 0);
    chk("R1 reset armed", armed, 0);
    chk("R1 reset exec",  exec_pulse, 0);
  endtask

  task automatic t_single();
    gen_ready = 1'b0;
    push(32'hABCD_EF80, 32'd4, 32'h1234_5678);
    tick(); chk("R2 read pulse", fifo_rd, 1); chk("R2 no early load", gen_load, 0);
    tick(); chk("R2 read single", fifo_rd, 0); chk("R2 load", gen_load, 1);
    chk("R2 step word", gen_step, 32'h1234_5678);
    chk("R2 cfg bits", gen_cfg, 32'hABCD_EF80 >> 7);
    tick(); chk("R2 load single", gen_load, 0); chk("R3 waits ready", armed, 0);
    tick(); chk("R3 still not ready", armed, 0);
    gen_ready = 1'b1;
    tick(); chk("R3 armed on ready", armed, 1);
    trigger = 1'b1;
    tick(); chk("R3 trigger leaves armed", armed, 0);
    repeat (4) tick();
    chk("R5 no start at T+1", gen_start, 0);
    tick(); chk("R5 start at T+2", gen_start, 1); chk("R5 exec pulse", exec_pulse, 1);
    tick(); chk("R5 exec one cycle", exec_pulse, 0); chk("R6 start held", gen_start, 1);
    gen_done = 1'b1; trigger = 1'b0;
    tick(); gen_done = 1'b0;
    chk("R6 idle after empty", gen_start, 0); chk("R1 idle step cleared", gen_step, 0);
    tick(); chk("R6 stays idle", fifo_rd | armed | gen_start, 0);
  endtask

  task automatic t_profile();
    int first = 0, second = 0, arms = 0;
    logic prev = 1'b0;
    logic [31:0] last_step = '0;
    push(32'h0, 32'd3, 32'hA);
    push(32'h0, 32'd20, 32'hB);
    wait_armed("R3 profile armed");
    trigger = 1'b1;
    for (int i = 1; i <= 30; i++) begin
      tick();
      if (i == 2) trigger = 1'b0;
      if (armed) arms++;
      if (gen_load) last_step = gen_step;
      if (gen_start && !prev) begin
        if (first == 0) first = i; else second = i;
      end
      prev = gen_start;
      gen_done = gen_start;
    end
    gen_done = 1'b0;
    chk("R5 profile first start", first, 5);
    chk("R4 second start on same time base", second, 22);
    chk("R4 no re-arm inside profile", arms, 0);
    chk("R4 second step loaded", last_step, 32'hB);
    chk("R6 idle after profile", armed | gen_start, 0);
  endtask

  task automatic t_repeat();
    int n, runs = 0;
    rep_mode = 1'b1; rep_n = 8'd3;
    push(32'h0, 32'd2, 32'hC);
    for (int r = 0; r < 3; r++) begin
      wait_armed("R7 re-armed between runs");
      trigger = 1'b1; tick(); trigger = 1'b0;
      wait_start(n);
      chk("R7 run timing restarts at trigger", n, 4);
      if (gen_start) runs++;
      gen_done = 1'b1; tick(); gen_done = 1'b0;
    end
    repeat (4) tick();
    chk("R7 run count", runs, 3);
    chk("R7 no fourth arm", armed | gen_start, 0);
    rep_mode = 1'b0; rep_n = 8'd1;
  endtask

  task automatic t_pause();
    push(32'h0, 32'd10, 32'hD);
    wait_armed("R9 armed");
    trigger = 1'b1; tick(); trigger = 1'b0; tick();
    pause = 1'b1;
    repeat (6) tick();
    chk("R9 frozen no start", gen_start, 0);
    pause = 1'b0;
    repeat (9) tick();
    chk("R9 start delayed, not yet", gen_start, 0);
    tick(); chk("R9 start delayed by pause", gen_start, 1);
    gen_done = 1'b1; tick(); gen_done = 1'b0;
  endtask

  task automatic t_stop();
    push(32'h0, 32'd1, 32'hE);
    wait_armed("R10 armed");
    stop = 1'b1; trigger = 1'b1;
    tick(); tick(); chk("R10 trigger ignored in stop", armed, 1);
    stop = 1'b0;
    tick(); tick(); chk("R10 held trigger not accepted", armed, 1);
    trigger = 1'b0; tick();
    trigger = 1'b1; tick(); trigger = 1'b0;
    tick(); tick(); chk("R10 fresh trigger starts", gen_start, 1);
    gen_done = 1'b1; tick(); gen_done = 1'b0;
  endtask

  task automatic t_abort();
    int n;
    push(32'h0, 32'd50, 32'hF);
    push(32'h0, 32'd60, 32'h10);
    wait_armed("R8 armed");
    trigger = 1'b1; tick(); trigger = 1'b0;
    repeat (3) tick();
    pause = 1'b1; host_abort = 1'b1;
    tick(); host_abort = 1'b0;
    chk("R8 flush starts", fifo_flush, 1);
    chk("R8 idle despite pause", armed | gen_start, 0);
    repeat (4) tick();
    chk("R8 flush fifth cycle", fifo_flush, 1);
    tick(); chk("R8 flush ends after 5", fifo_flush, 0);
    pause = 1'b0;
    chk("R8 fifo flushed", fifo_empty, 1);
    tick(); tick(); chk("R8 stays idle", fifo_rd | armed | gen_start, 0);
    push(32'h0, 32'd0, 32'h11);
    wait_armed("R8 armed again");
    trigger = 1'b1; tick(); trigger = 1'b0;
    wait_start(n);
    chk("R5 zero timestamp start", n, 2);
    pos_err = 1'b1; tick(); pos_err = 1'b0;
    chk("R8 position error stops", gen_start, 0);
    chk("R8 position error flush", fifo_flush, 1);
    repeat (6) tick();
    push(32'h0, 32'd5, 32'h12);
    wait_armed("R8 armed third");
    int_reset = 1'b1; tick(); int_reset = 1'b0;
    chk("R8 internal reset disarms", armed, 0);
    repeat (6) tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_single();
    t_profile();
    t_repeat();
    t_pause();
    t_stop();
    t_abort();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule